// File: doc/BRIEF.md
# PLL Lock Status and Interrupt Register Slice

This slice sits between an external PLL lock detector and a simple synchronous register bus. It takes the detector's raw lock level, passes it through a two-stage synchronizer and presents a qualified lock status. Any write to the synthesizer, reference-divider or control offset forces that status low for at least one cycle, so software always sees a fresh lock event after it retunes the loop.

Two sticky event flags record lock activity. The change flag sets on every transition of the lock status, in either direction. The loss flag sets only when the status falls. Software clears each flag by writing 1 to its bit; writing 0 leaves it alone. An interrupt request is raised while the interrupt enable and the change flag are both set. The slice also stores the control bits for output halving, a two-bit frequency-modulation select and PLL enable, and drives them out as plain level outputs.

The lock status is tracked by a two-state machine. ST_UNLOCKED moves to ST_LOCKED on transition T_ACQUIRE, taken when the synchronized input is high and no retune write is present. ST_LOCKED moves back to ST_UNLOCKED on T_DROP when the synchronized input is low, or on T_FORCE when a retune write arrives. In every other case the state holds.

Top module: `pll_lock_regs`

## Requirements
- R1: After reset, the status register (offset 0x3) and the control register (offset 0x4) read 0x00, and irq, lock_stat, div2_sel, fm_sel and pll_en are all 0.
- R2: A rising lock_raw reaches lock_stat on the third rising clock edge after it is applied (two synchronizer stages plus the state register); after two edges lock_stat is still 0.
- R3: A bus write to offset 0x0 (synthesizer), 0x1 (reference divider) or 0x4 (control) forces lock_stat to 0 at the write edge; if lock_raw stays high, lock_stat returns to 1 on the next edge.
- R4: Status register bit 3 reads the lock status; writes to offset 0x3 never change it.
- R5: Status register bit 4 (change flag) sets on every transition of the lock status, rising or falling.
- R6: Status register bit 0 (loss flag) sets only when the lock status goes from 1 to 0, never on a rise.
- R7: Writing 1 to bit 4 or bit 0 of offset 0x3 clears that flag; writing 0 leaves it unchanged.
- R8: When a flag's set event and a write-1 clear of that flag occur on the same edge, the flag ends set.
- R9: Status register bit 7 is a read/write interrupt enable; irq is 1 exactly while bit 7 and bit 4 are both 1.
- R10: Control register bit 4 drives div2_sel, bits 2:1 drive fm_sel[1:0] and bit 0 drives pll_en; bits 7:5 and 3 read as 0.
- R11: Status register bits 6:5 and 2:1 read as 0; offsets 0x0, 0x1, 0x2, 0x5, 0x6 and 0x7 read 0x00, and a write to offset 0x2 does not disturb the lock status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register and synchronizer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lock_raw | input | 1 | Unsynchronized lock level from the detector |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe, one write per cycle it is high |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| irq | output | 1 | Lock interrupt request |
| lock_stat | output | 1 | Qualified lock status |
| div2_sel | output | 1 | Output halving select |
| fm_sel | output | 2 | Frequency-modulation select |
| pll_en | output | 1 | PLL enable |

## Verification
A wrong lock state shows at lock_stat and at status bit 3 on the edge where it goes wrong, and a missed or spurious transition leaves the change or loss flag in the wrong value from that same edge until software clears it. Because the flags are sticky, a single-cycle glitch in the state machine, such as a missed T_FORCE after a control write, stays visible through a read of offset 0x3 on the following cycle. A flag that loses a same-edge set against a clear reads back as 0 immediately after the write, and an interrupt gating error shows at irq in the cycle after the enable or flag changes.

// File: rtl/pll_lock_pkg.sv
package pll_lock_pkg;

    localparam int DATA_W = 8;

    // register offsets
    localparam int OFS_SYN  = 0;
    localparam int OFS_REF  = 1;
    localparam int OFS_STAT = 3;
    localparam int OFS_CTL  = 4;

    // status register bit positions
    localparam int B_IE  = 7;
    localparam int B_CHG = 4;
    localparam int B_LK  = 3;
    localparam int B_LOS = 0;

    // control register bit positions
    localparam int B_DIV2  = 4;
    localparam int B_FM_LO = 1;
    localparam int B_FM_HI = 2;
    localparam int B_EN    = 0;

    // event flag indices
    localparam int N_FLAGS = 2;
    localparam int F_CHG   = 0;
    localparam int F_LOS   = 1;

    typedef enum logic {
        ST_UNLOCKED = 1'b0,
        ST_LOCKED   = 1'b1
    } lock_state_e;

endpackage

// File: rtl/lock_sync.sv
module lock_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[i] <= 1'b0;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/lock_fsm.sv
module lock_fsm
    import pll_lock_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sync_lock,
    input  logic force_clr,
    output logic lock,
    output logic ev_rise,
    output logic ev_fall
);
    lock_state_e state, nxt;

    // next-state selection
    always_comb begin
        nxt = state;
        unique case (state)
            ST_UNLOCKED: if (sync_lock && !force_clr) nxt = ST_LOCKED;   // T_ACQUIRE
            ST_LOCKED:   if (force_clr)               nxt = ST_UNLOCKED; // T_FORCE
                         else if (!sync_lock)         nxt = ST_UNLOCKED; // T_DROP
            default:                                  nxt = ST_UNLOCKED;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_UNLOCKED;
        else        state <= nxt;
    end

    // outputs
    always_comb begin
        lock    = 1'b0;
        ev_rise = 1'b0;
        ev_fall = 1'b0;
        unique case (state)
            ST_UNLOCKED: ev_rise = (nxt == ST_LOCKED);
            ST_LOCKED: begin
                lock    = 1'b1;
                ev_fall = (nxt == ST_UNLOCKED);
            end
            default: ;
        endcase
    end

    // R2: the state machine never enters ST_LOCKED without a high synchronized input
    p_acquire_needs_sync_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock) |-> $past(sync_lock));

    // R3: a retune write always leaves the machine unlocked
    p_force_drops_r3: assert property (@(posedge clk) disable iff (!rst_n)
        force_clr |=> !lock);
endmodule

// File: rtl/event_flags.sv
module event_flags #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_ev,
    input  logic [N-1:0] clr_w1,
    output logic [N-1:0] flag
);
    generate
        for (genvar i = 0; i < N; i++) begin : g_flag
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)         flag[i] <= 1'b0;
                else if (set_ev[i]) flag[i] <= 1'b1;   // R8: set beats clear
                else if (clr_w1[i]) flag[i] <= 1'b0;
            end

            // R7: a set flag stays set unless software clears it
            p_sticky_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (flag[i] && !clr_w1[i]) |=> flag[i]);

            // R8: a set event always leaves the flag set
            p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
                set_ev[i] |=> flag[i]);
        end
    endgenerate
endmodule

// File: rtl/pll_lock_regs.sv
module pll_lock_regs
    import pll_lock_pkg::*;
#(
    parameter int ADDR_W      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lock_raw,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              lock_stat,
    output logic              div2_sel,
    output logic [1:0]        fm_sel,
    output logic              pll_en
);
    localparam logic [ADDR_W-1:0] A_SYN  = ADDR_W'(OFS_SYN);
    localparam logic [ADDR_W-1:0] A_REF  = ADDR_W'(OFS_REF);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
    localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(OFS_CTL);

    logic              sync_q;
    logic              lock_q;
    logic              ev_rise, ev_fall;
    logic              wr_stat, wr_ctl, retune;
    logic [N_FLAGS-1:0] set_ev, clr_w1, flags;
    logic              ie_q;
    logic              div2_q, en_q;
    logic [1:0]        fm_q;
    logic              unused_wbits;

    assign unused_wbits = ^{bus_wdata[6:5], bus_wdata[3]};

    // write decode
    assign wr_stat = bus_wr && (bus_addr == A_STAT);
    assign wr_ctl  = bus_wr && (bus_addr == A_CTL);
    assign retune  = bus_wr && ((bus_addr == A_SYN) || (bus_addr == A_REF) || (bus_addr == A_CTL));

    lock_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (lock_raw),
        .q    (sync_q)
    );

    lock_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_lock(sync_q),
        .force_clr(retune),
        .lock     (lock_q),
        .ev_rise  (ev_rise),
        .ev_fall  (ev_fall)
    );

    assign set_ev[F_CHG] = ev_rise || ev_fall;
    assign set_ev[F_LOS] = ev_fall;
    assign clr_w1[F_CHG] = wr_stat && bus_wdata[B_CHG];
    assign clr_w1[F_LOS] = wr_stat && bus_wdata[B_LOS];

    event_flags #(.N(N_FLAGS)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set_ev(set_ev),
        .clr_w1(clr_w1),
        .flag  (flags)
    );

    // interrupt enable and control bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ie_q   <= 1'b0;
            div2_q <= 1'b0;
            fm_q   <= 2'b00;
            en_q   <= 1'b0;
        end else begin
            if (wr_stat) ie_q <= bus_wdata[B_IE];
            if (wr_ctl) begin
                div2_q <= bus_wdata[B_DIV2];
                fm_q   <= bus_wdata[B_FM_HI:B_FM_LO];
                en_q   <= bus_wdata[B_EN];
            end
        end
    end

    // read mux
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_STAT) begin
            bus_rdata[B_IE]  = ie_q;
            bus_rdata[B_CHG] = flags[F_CHG];
            bus_rdata[B_LK]  = lock_q;
            bus_rdata[B_LOS] = flags[F_LOS];
        end else if (bus_addr == A_CTL) begin
            bus_rdata[B_DIV2]          = div2_q;
            bus_rdata[B_FM_HI:B_FM_LO] = fm_q;
            bus_rdata[B_EN]            = en_q;
        end
    end

    assign irq       = ie_q && flags[F_CHG];
    assign lock_stat = lock_q;
    assign div2_sel  = div2_q;
    assign fm_sel    = fm_q;
    assign pll_en    = en_q;

    // R5: every lock transition leaves the change flag set
    p_change_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_stat != $past(lock_stat)) |-> flags[F_CHG]);

    // R6: a falling lock leaves the loss flag set
    p_loss_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock_stat) |-> flags[F_LOS]);

    // R6: the loss flag can only appear on a falling lock
    p_loss_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[F_LOS]) |-> $fell(lock_stat));

    // R9: no request without the enable
    p_irq_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ie_q);

    // R3: a retune write seen at the bus drops the lock status
    p_retune_port_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr == A_CTL)) |=> !lock_stat);
endmodule

// File: tb/sim_pll_lock_regs.sv
module sim_pll_lock_regs;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lock_raw = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq, lock_stat, div2_sel, pll_en;
    logic [1:0] fm_sel;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    pll_lock_regs u0 (
        .clk(clk), .rst_n(rst_n), .lock_raw(lock_raw),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq), .lock_stat(lock_stat),
        .div2_sel(div2_sel), .fm_sel(fm_sel), .pll_en(pll_en)
    );

    // control write data and expected readback {wdata, expected}
    localparam logic [15:0] CTL_VEC [6] = '{
        16'hFF_17, 16'h00_00, 16'h10_10, 16'h06_06, 16'h09_01, 16'hE8_00
    };

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic read_check(input string tag, input logic [2:0] a, input logic [7:0] exp);
        bus_addr = a;
        #1;
        check(tag, bus_rdata, exp);
    endtask

    task automatic ticks(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        read_check("R1 status", 3'd3, 8'h00);
        read_check("R1 control", 3'd4, 8'h00);
        check("R1 outputs", {3'b0, irq, lock_stat, div2_sel, fm_sel, pll_en}, 8'h00);

        // R10 control register table
        foreach (CTL_VEC[i]) begin
            bus_write(3'd4, CTL_VEC[i][15:8]);
            read_check("R10 ctl readback", 3'd4, CTL_VEC[i][7:0]);
            check("R10 ctl ports", {4'b0, div2_sel, fm_sel, pll_en},
                  {4'b0, CTL_VEC[i][4], CTL_VEC[i][2:1], CTL_VEC[i][0]});
        end

        // R11 other offsets read zero
        read_check("R11 off0", 3'd0, 8'h00);
        read_check("R11 off1", 3'd1, 8'h00);
        read_check("R11 off2", 3'd2, 8'h00);
        read_check("R11 off5", 3'd5, 8'h00);
        read_check("R11 off6", 3'd6, 8'h00);
        read_check("R11 off7", 3'd7, 8'h00);

        // R2 synchronizer latency
        lock_raw = 1'b1;
        ticks(2);
        check("R2 not yet locked", {7'b0, lock_stat}, 8'h00);
        ticks(1);
        check("R2 locked", {7'b0, lock_stat}, 8'h01);
        read_check("R5 change on rise", 3'd3, 8'h18);

        // R9 / R7 enable with flag bit written 0
        bus_write(3'd3, 8'h80);
        read_check("R7 write0 keeps flag", 3'd3, 8'h98);
        check("R9 irq on", {7'b0, irq}, 8'h01);
        bus_write(3'd3, 8'h90);
        check("R9 irq off after clear", {7'b0, irq}, 8'h00);
        read_check("R7 w1c change", 3'd3, 8'h88);

        // R4 lock bit read-only
        bus_write(3'd3, 8'h08);
        read_check("R4 lock unchanged", 3'd3, 8'h08);
        bus_write(3'd3, 8'h00);
        read_check("R4 lock unchanged write0", 3'd3, 8'h08);

        // R3 control write forces unlock
        bus_write(3'd4, 8'h01);
        read_check("R3 ctl forces low", 3'd3, 8'h11);
        check("R10 pll_en", {7'b0, pll_en}, 8'h01);
        ticks(1);
        read_check("R3 relock", 3'd3, 8'h19);
        bus_write(3'd3, 8'h11);
        read_check("R7 w1c both", 3'd3, 8'h08);

        // R3 synthesizer and reference-divider writes
        bus_write(3'd0, 8'hFF);
        read_check("R3 syn forces low", 3'd3, 8'h11);
        ticks(1);
        bus_write(3'd3, 8'h11);
        bus_write(3'd1, 8'h5A);
        read_check("R3 ref forces low", 3'd3, 8'h11);
        ticks(1);
        bus_write(3'd3, 8'h11);
        read_check("R3 cleared", 3'd3, 8'h08);

        // R11 write to offset 2 has no effect on lock
        bus_write(3'd2, 8'hFF);
        read_check("R11 off2 write", 3'd3, 8'h08);
        read_check("R11 off2 reads zero", 3'd2, 8'h00);

        // R6 loss only on fall
        lock_raw = 1'b0;
        ticks(3);
        read_check("R6 fall sets loss", 3'd3, 8'h11);
        bus_write(3'd3, 8'h11);
        read_check("R7 clear after fall", 3'd3, 8'h00);
        lock_raw = 1'b1;
        ticks(3);
        read_check("R6 no loss on rise", 3'd3, 8'h18);
        bus_write(3'd3, 8'h10);
        read_check("R7 clear change", 3'd3, 8'h08);

        // R8 set wins against same-edge clear
        lock_raw = 1'b0;
        ticks(2);
        bus_write(3'd3, 8'h11);
        read_check("R8 set wins", 3'd3, 8'h11);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule